// File: doc/BRIEF.md
# Cyclic Fold Activation Unit

This unit follows a narrow wrapping accumulator in a quantized inference datapath. It takes the signed accumulator result and applies a continuous periodic function to it. The period of that function equals the full span of the accumulator, so the result is the same whether or not the running sum overflowed. Values of small magnitude pass through unchanged. Beyond a breakpoint, large magnitudes are folded back linearly toward zero. The fold reaches zero exactly where the two's-complement value wraps from its most negative code to its most positive code.

The accumulator width `ACC_W` (written b below) and the fold slope `SLOPE` (k, which must be 2 or 4) are fixed at elaboration. The breakpoint is T = floor(k·2^(b-1)/(k+1)). With the default b = 8 this gives T = 85 for k = 2 and T = 102 for k = 4. The result is b+1 bits wide and is registered once. A valid flag travels alongside it. The register updates only when a valid sample arrives.

Because the input is already a b-bit two's-complement value, the input is its own centred representative m in [-2^(b-1), 2^(b-1)).

Top module: `cyc_fold_act`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and act_o is 0.
- R2: valid_o equals valid_i as sampled on the previous rising clock edge.
- R3: For a valid sample m with -T <= m <= T, act_o one cycle later equals m, sign-extended to b+1 bits.
- R4: For a valid sample m > T, act_o one cycle later equals k·2^(b-1) - k·m. This value is never negative.
- R5: For a valid sample m < -T, act_o one cycle later equals -k·2^(b-1) - k·m. This value is never positive.
- R6: The function is continuous across the wrap point. m = -2^(b-1) gives 0, and every output lies in [-T, T].
- R7: A cycle with valid_i low leaves act_o unchanged in the following cycle, whatever acc_i holds.
- R8: The same rules hold with k = 4 (T = 102 for b = 8), where the folds become steeper (factor 4 instead of 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | acc_i holds a sample this cycle |
| acc_i | input | ACC_W | Signed wrapped accumulator result |
| valid_o | output | 1 | act_o was loaded from a sample in the previous cycle |
| act_o | output | ACC_W+1 | Signed folded activation |

## Verification
Two things can meet in the same cycle. The first is the registered result of one sample on the output. The second is the decision for the next cycle: either a new sample from a different fold region is loaded, or the hold path keeps the current value while valid_i is low and acc_i carries a value that would fold differently.

The bench first sweeps every b-bit code back to back, so each cycle crosses from one region or code to the next. It then runs a strided pattern with valid gaps, where acc_i keeps changing during the idle cycles. On every clock, an integer reference with its own expected-value register judges both a k = 2 and a k = 4 instance.

// File: rtl/cfa_pkg.sv
package cfa_pkg;
  typedef enum logic [1:0] {
    REG_PASS = 2'd0,
    REG_HIGH = 2'd1,
    REG_LOW  = 2'd2
  } fold_region_e;
endpackage

// File: rtl/cfa_region.sv
module cfa_region
  import cfa_pkg::*;
#(
  parameter int ACC_W = 8,
  parameter int SLOPE = 2
) (
  input  logic signed [ACC_W-1:0] acc_i,
  output fold_region_e            region_o
);
  localparam int HALF   = 1 << (ACC_W - 1);
  localparam int THRESH = (SLOPE * HALF) / (SLOPE + 1); // rounded toward zero
  localparam logic signed [ACC_W:0] T_POS = (ACC_W+1)'(THRESH);
  localparam logic signed [ACC_W:0] T_NEG = -T_POS;

  logic signed [ACC_W:0] acc_x;
  assign acc_x = (ACC_W+1)'(acc_i);

  always_comb begin
    if (acc_x > T_POS)      region_o = REG_HIGH;
    else if (acc_x < T_NEG) region_o = REG_LOW;
    else                    region_o = REG_PASS;
  end
endmodule

// File: rtl/cfa_fold.sv
module cfa_fold
  import cfa_pkg::*;
#(
  parameter int ACC_W = 8,
  parameter int SLOPE = 2,
  parameter int OUT_W = ACC_W + 1
) (
  input  logic signed [ACC_W-1:0] acc_i,
  input  fold_region_e            region_i,
  output logic signed [OUT_W-1:0] fold_o
);
  localparam int SHIFT = $clog2(SLOPE);
  localparam int INT_W = ACC_W + SHIFT + 2;
  localparam logic signed [INT_W-1:0] SPAN = INT_W'(SLOPE) << (ACC_W - 1);

  logic signed [INT_W-1:0] acc_x, scaled, high_v, low_v, sel;
  assign acc_x = INT_W'(acc_i);

  generate
    if ((1 << SHIFT) == SLOPE) begin : g_shift
      assign scaled = acc_x <<< SHIFT;
    end else begin : g_mult
      assign scaled = acc_x * INT_W'(SLOPE);
    end
  endgenerate

  assign high_v = SPAN - scaled;
  assign low_v  = -SPAN - scaled;

  always_comb begin
    case (region_i)
      REG_HIGH: sel = high_v;
      REG_LOW:  sel = low_v;
      default:  sel = acc_x;
    endcase
  end

  assign fold_o = OUT_W'(sel);
endmodule

// File: rtl/cfa_out_reg.sv
module cfa_out_reg #(
  parameter int OUT_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [OUT_W-1:0] data_i,
  output logic                    valid_o,
  output logic signed [OUT_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/cyc_fold_act.sv
module cyc_fold_act
  import cfa_pkg::*;
#(
  parameter int ACC_W = 8,
  parameter int SLOPE = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic signed [ACC_W-1:0] acc_i,
  output logic                   valid_o,
  output logic signed [ACC_W:0]  act_o
);
  localparam int OUT_W = ACC_W + 1;

  fold_region_e            region;
  logic signed [OUT_W-1:0] fold_val;

  cfa_region #(.ACC_W(ACC_W), .SLOPE(SLOPE)) i_region (
    .acc_i   (acc_i),
    .region_o(region)
  );

  cfa_fold #(.ACC_W(ACC_W), .SLOPE(SLOPE), .OUT_W(OUT_W)) i_fold (
    .acc_i   (acc_i),
    .region_i(region),
    .fold_o  (fold_val)
  );

  cfa_out_reg #(.OUT_W(OUT_W)) i_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .data_i (fold_val),
    .valid_o(valid_o),
    .data_o (act_o)
  );
endmodule

// File: rtl/cyc_fold_act_chk.sv
module cyc_fold_act_chk #(
  parameter int ACC_W = 8,
  parameter int SLOPE = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic signed [ACC_W-1:0] acc_i,
  input logic                    valid_o,
  input logic signed [ACC_W:0]   act_o
);
  localparam int HALF   = 1 << (ACC_W - 1);
  localparam int THRESH = (SLOPE * HALF) / (SLOPE + 1);
  localparam logic signed [ACC_W:0] T_POS = (ACC_W+1)'(THRESH);
  localparam logic signed [ACC_W:0] T_NEG = -T_POS;

  logic signed [ACC_W:0] acc_w;
  assign acc_w = (ACC_W+1)'(acc_i);

  a_r2_valid_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_valid_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r3_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && acc_w <= T_POS && acc_w >= T_NEG) |=> act_o == $past(acc_w));
  a_r4_high_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && acc_w > T_POS) |=> act_o >= 0);
  a_r5_low_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && acc_w < T_NEG) |=> act_o <= 0);
  a_r6_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o <= T_POS && act_o >= T_NEG);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(act_o));
endmodule

bind cyc_fold_act cyc_fold_act_chk #(.ACC_W(ACC_W), .SLOPE(SLOPE)) i_chk (.*);

// File: tb/test_cyc_fold_act.sv
`timescale 1ns/1ps
module test_cyc_fold_act;
  localparam int ACC_W = 8;
  localparam int HALF  = 1 << (ACC_W - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_in = 1'b0;
  logic signed [ACC_W-1:0] acc_in = '0;
  logic valid_k2, valid_k4;
  logic signed [ACC_W:0] act_k2, act_k4;

  int checks = 0;
  int errors = 0;
  bit exp_valid = 1'b0;
  int exp2 = 0, exp4 = 0;
  string tag2 = "R1", tag4 = "R1";

  always #2.5 clk = ~clk;

  cyc_fold_act #(.ACC_W(ACC_W), .SLOPE(2)) i_cyc_fold_act (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_in), .acc_i(acc_in),
    .valid_o(valid_k2), .act_o(act_k2));

  cyc_fold_act #(.ACC_W(ACC_W), .SLOPE(4)) i_cyc_fold_act_k4 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_in), .acc_i(acc_in),
    .valid_o(valid_k4), .act_o(act_k4));

  function automatic int thresh(int k);
    return (k * HALF) / (k + 1);
  endfunction

  function automatic int ref_act(int z, int k);
    int t = thresh(k);
    if (z > t)  return k * HALF - k * z;
    if (z < -t) return -k * HALF - k * z;
    return z;
  endfunction

  function automatic string region_tag(int z, int k);
    int t = thresh(k);
    if (z == -HALF) return "R6";
    if (z > t)      return "R4";
    if (z < -t)     return "R5";
    return "R3";
  endfunction

  task automatic chk(int got, int exp, string req);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_outputs();
    int a2 = int'(act_k2);
    int a4 = int'(act_k4);
    chk(int'(valid_k2), int'(exp_valid), "R2");
    chk(int'(valid_k4), int'(exp_valid), "R2");
    chk(a2, exp2, tag2);
    chk(a4, exp4, {"R8/", tag4});
    chk(int'(a2 <= thresh(2) && a2 >= -thresh(2)), 1, "R6");
    chk(int'(a4 <= thresh(4) && a4 >= -thresh(4)), 1, "R6");
  endtask

  task automatic step(bit v, int z);
    @(negedge clk);
    check_outputs();
    valid_in  = v;
    acc_in    = ACC_W'(z);
    exp_valid = v;
    if (v) begin
      exp2 = ref_act(z, 2);
      exp4 = ref_act(z, 4);
      tag2 = region_tag(z, 2);
      tag4 = region_tag(z, 4);
    end else begin
      tag2 = "R7";
      tag4 = "R7";
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state, with a nonzero input applied
    repeat (3) @(negedge clk);
    valid_in = 1'b1;
    acc_in   = ACC_W'(100);
    @(negedge clk);
    chk(int'(valid_k2), 0, "R1");
    chk(int'(act_k2), 0, "R1");
    chk(int'(valid_k4), 0, "R1");
    chk(int'(act_k4), 0, "R1");
    valid_in = 1'b0;
    acc_in   = '0;
    @(negedge clk);
    rst_n = 1'b1;
    tag2 = "R1";
    tag4 = "R1";

    // exhaustive back-to-back sweep of every code
    for (int z = -HALF; z < HALF; z++) step(1'b1, z);

    // strided pattern with idle gaps; acc_i keeps moving while idle
    for (int i = 0; i < 96; i++) begin
      int z = ((i * 37) % (2 * HALF)) - HALF;
      step(i % 3 != 0, z);
    end

    // explicit wrap and breakpoint neighbours
    step(1'b1, HALF - 1);
    step(1'b1, -HALF);
    step(1'b0, 3);
    step(1'b1, thresh(2) + 1);
    step(1'b1, -thresh(4) - 1);
    step(1'b0, 0);
    @(negedge clk);
    check_outputs();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule